// File: doc/BRIEF.md
# Time-of-Day Event Capture Unit

This block timestamps external pulse events against one of several local time-of-day clocks. Each of its event pins passes through a synchroniser and an edge detector. When a pin is armed and sees a rising edge, the unit copies the seconds and nanoseconds of the pin's chosen time domain into that pin's own capture registers. It also sets a sticky per-pin event flag. A flat register port lets software arm pins, choose domains, read captured times, clear flags and mask the single combined interrupt line.

The time-of-day counters live outside the block. Each domain presents its seconds and nanoseconds on packed input buses. The capture path stores the nanosecond value exactly as presented. A counter that has not yet rolled over can show a value in the band 0x3FFFFFF0 to 0x3FFFFFFF. Software folds such a value back into the previous second: it subtracts one second and uses 999,999,984 plus the low four bits as the nanoseconds.

Top module: `tod_capture_unit`

## Requirements
- R1: After reset, the flag register, the interrupt mask, every pin control register and every capture register read as zero, and the interrupt output is low.
- R2: A rising edge on an armed pin is seen through a two-flop synchroniser. The pin goes high between clock edges, and the capture registers then hold the domain time present on the third rising clock edge after that change.
- R3: A falling edge, or an input held steadily high, causes no capture and sets no flag.
- R4: Bits [1:0] of a pin's control register (address 8 + 4*pin) are its sync mode. The pin captures only when the mode is 3. Modes 0, 1 and 2 leave it inactive. The control register reads back what was written in bits [5:4] and [1:0].
- R5: Bits [5:4] of the control register select the time domain (0, 1 or 2). Code 3 selects no domain and suppresses capture.
- R6: Each capture sets bit `pin` of the flag register (address 0). A new edge while that flag is still set overwrites the captured time, and the flag stays set.
- R7: Writing address 0 clears every flag bit written as 1 and leaves the bits written as 0 unchanged. A capture in the same cycle as a clear of its bit leaves the flag set.
- R8: The interrupt output is high exactly when some flag bit is set whose bit in the mask register (address 1) is also set.
- R9: Readback is as follows: nanoseconds at 8 + 4*pin + 1, seconds bits [31:0] at +2, and the upper seconds bits at +3. The nanoseconds are stored raw, including values in the not-yet-rolled band 0x3FFFFFF0..0x3FFFFFFF.
- R10: Pins are independent: a capture on one pin changes neither the captured time nor the flag of any other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NUM_PINS | Asynchronous event inputs |
| tod_sec_i | input | NUM_DOM*SEC_W | Seconds of each time domain, domain 0 in the low bits |
| tod_ns_i | input | NUM_DOM*NS_W | Nanoseconds of each time domain, domain 0 in the low bits |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | 32 | Register read data, combinational from rd_addr_i |
| irq_o | output | 1 | Combined event interrupt |

## Verification
The hardest case to reach from the ports is a capture that lands in the same clock cycle as a software clear of the same flag bit. The two must collide exactly at the edge where the synchronised rise is registered. The stimulus raises the pin between edges, counts two clock edges, and then schedules the write-one-to-clear so that it commits on the third edge together with the capture. A domain whose counter is frozen inside the not-yet-rolled nanosecond band drives the fold-back case deterministically.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
   localparam int REG_W         = 32;
   localparam int ADDR_FLAGS    = 0;
   localparam int ADDR_MASK     = 1;
   localparam int ADDR_PIN_BASE = 8;
   localparam int PIN_STRIDE    = 4;
   localparam int OFS_CTRL      = 0;
   localparam int OFS_NS        = 1;
   localparam int OFS_SEC_LO    = 2;
   localparam int OFS_SEC_HI    = 3;
   localparam int DOM_W         = 2;

   typedef enum logic [1:0] {
      SYNC_OFF   = 2'd0,
      SYNC_RSV1  = 2'd1,
      SYNC_RSV2  = 2'd2,
      SYNC_ARMED = 2'd3
   } sync_mode_e;

   typedef struct packed {
      logic [DOM_W-1:0] dom;
      sync_mode_e       sync;
   } pin_ctrl_t;
endpackage

// File: rtl/tcu_pin_sync.sv
module tcu_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tcu_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q[0] <= 1'b0;
            else        sh_q[0] <= pin_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q[g] <= 1'b0;
            else        sh_q[g] <= sh_q[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sh_q[STAGES-1];
   end

   assign rise_o = sh_q[STAGES-1] & ~prev_q;

   if (STAGES == 2) begin : g_chk2
      AST_EDGE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o |-> $past(pin_i, 2)) else $error("rise without pin high"); // R2
   end
endmodule

// File: rtl/tcu_pin_capture.sv
module tcu_pin_capture
   import tcu_pkg::*;
#(
   parameter int NUM_DOM = 3,
   parameter int SEC_W   = 48,
   parameter int NS_W    = 30
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rise_i,
   input  logic                     ctrl_we_i,
   input  logic [REG_W-1:0]         ctrl_wdata_i,
   input  logic [NUM_DOM*SEC_W-1:0] tod_sec_i,
   input  logic [NUM_DOM*NS_W-1:0]  tod_ns_i,
   output pin_ctrl_t                ctrl_o,
   output logic [SEC_W-1:0]         cap_sec_o,
   output logic [NS_W-1:0]          cap_ns_o,
   output logic                     hit_o
);
   pin_ctrl_t        ctrl_q;
   logic [SEC_W-1:0] sel_sec, cap_sec_q;
   logic [NS_W-1:0]  sel_ns, cap_ns_q;
   logic             dom_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we_i) begin
         ctrl_q.dom  <= ctrl_wdata_i[5:4];
         ctrl_q.sync <= sync_mode_e'(ctrl_wdata_i[1:0]);
      end
   end

   always_comb begin
      sel_sec = '0;
      sel_ns  = '0;
      dom_ok  = 1'b0;
      for (int d = 0; d < NUM_DOM; d++) begin
         if (ctrl_q.dom == DOM_W'(d)) begin
            sel_sec = tod_sec_i[d*SEC_W +: SEC_W];
            sel_ns  = tod_ns_i[d*NS_W +: NS_W];
            dom_ok  = 1'b1;
         end
      end
   end

   assign hit_o = rise_i && (ctrl_q.sync == SYNC_ARMED) && dom_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_sec_q <= '0;
         cap_ns_q  <= '0;
      end else if (hit_o) begin
         cap_sec_q <= sel_sec;
         cap_ns_q  <= sel_ns;
      end
   end

   assign ctrl_o    = ctrl_q;
   assign cap_sec_o = cap_sec_q;
   assign cap_ns_o  = cap_ns_q;

   AST_CAP_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_ns_q) |-> $past(rise_i)) else $error("capture without edge"); // R3
endmodule

// File: rtl/tcu_irq_agg.sv
module tcu_irq_agg #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_we_i,
   input  logic         mask_we_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] flags_o,
   output logic [N-1:0] mask_o,
   output logic         irq_o
);
   logic [N-1:0] flags_q, mask_q, clr;

   assign clr = clr_we_i ? wdata_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         mask_q  <= '0;
      end else begin
         flags_q <= (flags_q & ~clr) | set_i;
         if (mask_we_i) mask_q <= wdata_i;
      end
   end

   assign flags_o = flags_q;
   assign mask_o  = mask_q;
   assign irq_o   = |(flags_q & mask_q);

   for (genvar i = 0; i < N; i++) begin : g_chk
      AST_FLAG_RISE_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(flags_q[i]) && flags_q[i]) |-> $past(set_i[i])) else $error("flag rose alone"); // R6
      AST_FLAG_FALL_NEEDS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(flags_q[i]) && !flags_q[i]) |-> $past(clr_we_i && wdata_i[i])) else $error("flag fell alone"); // R7
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flags_q[i]) else $error("capture lost flag"); // R7
   end
endmodule

// File: rtl/tod_capture_unit.sv
module tod_capture_unit
   import tcu_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int NUM_DOM     = 3,
   parameter int SEC_W       = 48,
   parameter int NS_W        = 30,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PINS-1:0]      pin_i,
   input  logic [NUM_DOM*SEC_W-1:0] tod_sec_i,
   input  logic [NUM_DOM*NS_W-1:0]  tod_ns_i,
   input  logic                     wr_en_i,
   input  logic [ADDR_W-1:0]        wr_addr_i,
   input  logic [REG_W-1:0]         wr_data_i,
   input  logic [ADDR_W-1:0]        rd_addr_i,
   output logic [REG_W-1:0]         rd_data_o,
   output logic                     irq_o
);
   localparam int MAP_END = ADDR_PIN_BASE + NUM_PINS * PIN_STRIDE;

   if (NUM_PINS < 1 || NUM_PINS > REG_W) begin : g_bad_pins
      $error("tod_capture_unit: NUM_PINS out of range");
   end
   if (NUM_DOM < 1 || NUM_DOM > 3) begin : g_bad_dom
      $error("tod_capture_unit: NUM_DOM must be 1..3");
   end
   if (SEC_W <= REG_W || SEC_W > 2 * REG_W) begin : g_bad_sec
      $error("tod_capture_unit: SEC_W must be 33..64");
   end
   if (NS_W > REG_W) begin : g_bad_ns
      $error("tod_capture_unit: NS_W too wide");
   end
   if (MAP_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("tod_capture_unit: ADDR_W too small for the map");
   end

   logic [NUM_PINS-1:0] rise, hit, ctrl_we, flags, mask;
   pin_ctrl_t           ctrl [NUM_PINS];
   logic [SEC_W-1:0]    cap_sec [NUM_PINS];
   logic [NS_W-1:0]     cap_ns [NUM_PINS];

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign ctrl_we[p] = wr_en_i &&
         (wr_addr_i == ADDR_W'(ADDR_PIN_BASE + p * PIN_STRIDE + OFS_CTRL));

      tcu_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pin_i[p]),
         .rise_o (rise[p])
      );

      tcu_pin_capture #(.NUM_DOM(NUM_DOM), .SEC_W(SEC_W), .NS_W(NS_W)) cap_i (
         .clk          (clk),
         .rst_n        (rst_n),
         .rise_i       (rise[p]),
         .ctrl_we_i    (ctrl_we[p]),
         .ctrl_wdata_i (wr_data_i),
         .tod_sec_i    (tod_sec_i),
         .tod_ns_i     (tod_ns_i),
         .ctrl_o       (ctrl[p]),
         .cap_sec_o    (cap_sec[p]),
         .cap_ns_o     (cap_ns[p]),
         .hit_o        (hit[p])
      );
   end

   tcu_irq_agg #(.N(NUM_PINS)) agg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (hit),
      .clr_we_i  (wr_en_i && (wr_addr_i == ADDR_W'(ADDR_FLAGS))),
      .mask_we_i (wr_en_i && (wr_addr_i == ADDR_W'(ADDR_MASK))),
      .wdata_i   (wr_data_i[NUM_PINS-1:0]),
      .flags_o   (flags),
      .mask_o    (mask),
      .irq_o     (irq_o)
   );

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == ADDR_W'(ADDR_FLAGS)) rd_data_o = REG_W'(flags);
      if (rd_addr_i == ADDR_W'(ADDR_MASK))  rd_data_o = REG_W'(mask);
      for (int p = 0; p < NUM_PINS; p++) begin
         if (rd_addr_i == ADDR_W'(ADDR_PIN_BASE + p * PIN_STRIDE + OFS_CTRL))
            rd_data_o = REG_W'({ctrl[p].dom, 2'b00, ctrl[p].sync});
         if (rd_addr_i == ADDR_W'(ADDR_PIN_BASE + p * PIN_STRIDE + OFS_NS))
            rd_data_o = REG_W'(cap_ns[p]);
         if (rd_addr_i == ADDR_W'(ADDR_PIN_BASE + p * PIN_STRIDE + OFS_SEC_LO))
            rd_data_o = cap_sec[p][REG_W-1:0];
         if (rd_addr_i == ADDR_W'(ADDR_PIN_BASE + p * PIN_STRIDE + OFS_SEC_HI))
            rd_data_o = REG_W'(cap_sec[p] >> REG_W);
      end
   end

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flags != '0)) else $error("irq with no flag"); // R8
endmodule

// File: tb/tod_capture_unit_tb_top.sv
module tod_capture_unit_tb_top;
   localparam int NP = 8, ND = 3, SW = 48, NW = 30, AW = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP-1:0]   pins = '0;
   logic [ND*SW-1:0] tod_sec;
   logic [ND*NW-1:0] tod_ns;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0, rd_addr = '0;
   logic [31:0]     wr_data = '0;
   logic [31:0]     rd_data;
   logic            irq;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tod_capture_unit dut_i (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .tod_sec_i(tod_sec), .tod_ns_i(tod_ns),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
   );

   // time-of-day model
   logic [SW-1:0] m_sec [ND];
   logic [NW-1:0] m_ns [ND];
   int unsigned   m_inc [ND];

   initial begin
      m_sec[0] = 48'd5;              m_ns[0] = 30'd999_999_000; m_inc[0] = 8;
      m_sec[1] = 48'h1234_0000_0007; m_ns[1] = 30'd0;           m_inc[1] = 3;
      m_sec[2] = 48'd100;            m_ns[2] = 30'h3FFF_FFF5;   m_inc[2] = 0;
   end

   always @(posedge clk) begin
      for (int d = 0; d < ND; d++) begin
         logic [31:0] nx;
         nx = 32'(m_ns[d]) + m_inc[d];
         if (d < 2 && nx >= 32'd1_000_000_000) begin
            m_ns[d]  <= NW'(nx - 32'd1_000_000_000);
            m_sec[d] <= m_sec[d] + 1;
         end else begin
            m_ns[d] <= NW'(nx);
         end
      end
   end

   always_comb begin
      for (int d = 0; d < ND; d++) begin
         tod_sec[d*SW +: SW] = m_sec[d];
         tod_ns[d*NW +: NW]  = m_ns[d];
      end
   end

   typedef struct {
      int            pin;
      logic [SW-1:0] sec;
      logic [NW-1:0] ns;
   } exp_t;
   exp_t sb_q[$];

   function automatic int pa(int pin, int ofs);
      return 8 + 4 * pin + ofs;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd(int addr, output logic [31:0] d);
      @(negedge clk);
      rd_addr = AW'(addr);
      #1;
      d = rd_data;
   endtask

   task automatic wr(int addr, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   // driver: raise pin, push the expected capture taken at the third edge
   task automatic drive_capture(int pin, int dom);
      exp_t e;
      @(negedge clk) pins[pin] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      #1;
      e.pin = pin; e.sec = m_sec[dom]; e.ns = m_ns[dom];
      sb_q.push_back(e);
      @(posedge clk);
      @(negedge clk) pins[pin] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic drive_nocap(int pin);
      @(negedge clk) pins[pin] = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk) pins[pin] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // monitor: pop the oldest expected capture and compare readback
   task automatic monitor_pop(string req);
      exp_t e;
      logic [31:0] v_ns, v_lo, v_hi;
      if (sb_q.size() == 0) begin
         chk({req, " queue"}, 64'd0, 64'd1);
         return;
      end
      e = sb_q.pop_front();
      rd(pa(e.pin, 1), v_ns);
      rd(pa(e.pin, 2), v_lo);
      rd(pa(e.pin, 3), v_hi);
      chk({req, " ns"}, 64'(v_ns), 64'(e.ns));
      chk({req, " sec"}, {v_hi[15:0], v_lo}, 64'(e.sec));
   endtask

   initial begin
      logic [31:0] v, ns0;
      logic [47:0] fsec;
      logic [31:0] fns;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      rd(0, v);        chk("R1 flags", 64'(v), 0);
      rd(1, v);        chk("R1 mask", 64'(v), 0);
      rd(pa(0, 0), v); chk("R1 ctrl", 64'(v), 0);
      rd(pa(0, 1), v); chk("R1 capture", 64'(v), 0);
      chk("R1 irq", 64'(irq), 0);

      wr(pa(0, 0), 32'h03);
      wr(pa(1, 0), 32'h01);
      wr(pa(2, 0), 32'h33);
      wr(pa(3, 0), 32'h13);
      wr(pa(4, 0), 32'h23);
      rd(pa(3, 0), v); chk("R4 ctrl readback", 64'(v), 64'h13);

      drive_capture(0, 0);
      monitor_pop("R2 pin0 dom0");
      rd(0, v); chk("R6 flag set", 64'(v), 64'h01);
      chk("R8 masked irq", 64'(irq), 0);
      wr(1, 32'h01);
      #1 chk("R8 enabled irq", 64'(irq), 1);
      wr(0, 32'hFE);
      rd(0, v); chk("R7 write zero keeps", 64'(v), 64'h01);
      wr(0, 32'h01);
      rd(0, v); chk("R7 w1c clears", 64'(v), 0);
      chk("R8 irq drops", 64'(irq), 0);

      // falling edge: rise first, clear, then fall
      @(negedge clk) pins[0] = 1'b1;
      repeat (6) @(negedge clk);
      sb_q.delete();
      wr(0, 32'hFF);
      rd(pa(0, 1), ns0);
      @(negedge clk) pins[0] = 1'b0;
      repeat (6) @(negedge clk);
      rd(pa(0, 1), v); chk("R3 fall no capture", 64'(v), 64'(ns0));
      rd(0, v);        chk("R3 fall no flag", 64'(v), 0);

      drive_nocap(1);
      rd(0, v); chk("R4 mode1 inactive", 64'(v), 0);
      wr(pa(1, 0), 32'h02);
      drive_nocap(1);
      rd(0, v); chk("R4 mode2 inactive", 64'(v), 0);
      rd(pa(1, 1), v); chk("R4 no capture", 64'(v), 0);

      drive_nocap(2);
      rd(0, v); chk("R5 domain3 suppressed", 64'(v), 0);

      drive_capture(3, 1);
      monitor_pop("R5 pin3 dom1");
      drive_capture(4, 2);
      monitor_pop("R9 raw band");
      rd(pa(4, 1), fns);
      rd(pa(4, 2), v);
      fsec = 48'(v);
      if ((fns[29:0] & 30'h3FFF_FFF0) == 30'h3FFF_FFF0) begin
         fsec = fsec - 1;
         fns  = 32'd999_999_984 + 32'(fns[3:0]);
      end
      chk("R9 folded sec", 64'(fsec), 64'd99);
      chk("R9 folded ns", 64'(fns), 64'd999_999_989);

      rd(0, v);        chk("R10 per-pin flags", 64'(v), 64'h18);
      rd(pa(0, 1), v); chk("R10 pin0 untouched", 64'(v), 64'(ns0));

      repeat (20) @(negedge clk);
      drive_capture(3, 1);
      monitor_pop("R6 overwrite");
      rd(0, v); chk("R6 flag stays", 64'(v), 64'h18);

      chk("R8 unrelated mask", 64'(irq), 0);
      wr(1, 32'h10);
      #1 chk("R8 pin4 enabled", 64'(irq), 1);

      // capture and clear of the same bit in one cycle
      wr(0, 32'h18);
      begin
         exp_t e;
         @(negedge clk) pins[3] = 1'b1;
         @(posedge clk);
         @(posedge clk);
         #1;
         e.pin = 3; e.sec = m_sec[1]; e.ns = m_ns[1];
         sb_q.push_back(e);
         @(negedge clk);
         wr_en = 1'b1; wr_addr = AW'(0); wr_data = 32'h08;
         @(posedge clk);
         #1 wr_en = 1'b0;
         @(negedge clk) pins[3] = 1'b0;
         repeat (3) @(negedge clk);
      end
      rd(0, v); chk("R7 set wins", 64'(v), 64'h08);
      monitor_pop("R7 capture kept");

      wr(pa(0, 0), 32'h00);
      drive_nocap(0);
      rd(0, v); chk("R4 mode0 inactive", 64'(v & 32'h1), 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule